// File: doc/BRIEF.md
# Two-Bank Register Window with Bus Line Override

This block is the register front end of a byte-wide two-wire bus controller. Software reaches it through an 8-bit read/write port with a 5-bit offset. The lower half of the offset space is always the same. In the upper half, a bank bit decides which of two register sets is visible, except for two offsets that are shared by both banks. The protocol engine and the FIFO data paths are not part of this block. The block only stores the bytes that those parts would use.

One control register, at offset 0x0E, carries the bank bit and two line-level bits. The line-level bits let software hold the clock line or the data line low through the open-drain pull-low outputs. This is how firmware stalls a transfer. A write to these level bits takes effect only while a separate enable bit in bank 0 is set, so writes aimed at the other bits of the register cannot disturb the lines. When software reads the level bits, it gets the real pin states after a two-flop synchronizer. A line that software has released can therefore still read low while another device holds it.

The bank choice is a two-state machine. BANK_ZERO is the reset state. A write to 0x0E with bit 5 set moves it to BANK_ONE (transition SEL_HIGH). A write to 0x0E with bit 5 clear moves it back to BANK_ZERO (transition SEL_LOW). Any other cycle leaves the state where it is (HOLD).

Top module: `i2c_reg_window`

## Requirements
- R1: After reset the bank is 0, the level write-enable (bit 7 at bank-0 offset 0x1A) is 0, both level bits are 1, every stored byte is 0x00, and the drive outputs follow only the engine requests.
- R2: Bit 5 of offset 0x0E selects bank 1 when set and bank 0 when clear, and it reads back as written.
- R3: Offsets 0x10 to 0x1F, other than 0x18 and 0x19, reach separate storage in bank 0 and in bank 1. A write in one bank leaves the other bank's byte at the same offset unchanged.
- R4: Offsets 0x18 and 0x19 reach the same bytes whichever bank is selected.
- R5: Offsets 0x00 to 0x0F reach the same storage in both banks.
- R6: While the write-enable is 0, a write to 0x0E leaves both level bits unchanged, while bits 5..0 still take the written value.
- R7: While the write-enable is 1, writing bit 7 (clock level) or bit 6 (data level) of 0x0E as 0 asserts the matching pull-low output from the next cycle. Writing it as 1 releases that output.
- R8: Each pull-low output is the OR of the software override and the engine request. A released override never hides an engine pull-low.
- R9: Reads of 0x0E bits 7 and 6 return the clock and data pin levels through a two-flop synchronizer. A pin change becomes visible after the second rising clock edge, not after the first.
- R10: The write-enable bit exists only in bank 0. A write to offset 0x1A while bank 1 is selected does not open the level-write guard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Register offset |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| eng_scl_low | input | 1 | Protocol engine requests clock line low |
| eng_sda_low | input | 1 | Protocol engine requests data line low |
| scl_in | input | 1 | Sampled clock pin level |
| sda_in | input | 1 | Sampled data pin level |
| scl_drive_low | output | 1 | Open-drain pull-low enable, clock line |
| sda_drive_low | output | 1 | Open-drain pull-low enable, data line |

## Verification
A table of writes and read-backs switches banks several times. It places distinct bytes at the same banked offset, at a shared offset and at a low offset. This separates a correct remap from storage that ignores the bank bit, storage that wrongly banks 0x18/0x19, and storage that banks the lower half. Offset 0x0E is written with level bits 0 both with the enable closed and with it open, and the enable is also written from bank 1. These cases tell a working guard from one that is always open or that is decoded in the wrong bank. Engine requests, override values and an external device holding the line are combined against the drive outputs and the read-back. Each read-back is sampled one and two edges after a change, which pins down the OR of the drive sources and the synchronizer latency.

// File: rtl/bwin_pkg.sv
package bwin_pkg;

    // Fixed layout of the window (bit positions decoded by software)
    localparam int unsigned CTL3_OFF   = 14;  // 0x0E, visible in both banks
    localparam int unsigned CTL4_IDX   = 10;  // bank-0 offset 0x1A within upper half
    localparam int unsigned SHARED_A   = 8;   // 0x18 within upper half
    localparam int unsigned SHARED_B   = 9;   // 0x19 within upper half
    localparam int unsigned BANK_BIT   = 5;
    localparam int unsigned SDA_BIT    = 6;
    localparam int unsigned SCL_BIT    = 7;
    localparam int unsigned LVL_WE_BIT = 7;

    typedef enum logic {
        BANK_ZERO = 1'b0,
        BANK_ONE  = 1'b1
    } bank_e;

    typedef enum logic [1:0] {
        RG_LOW    = 2'd0,
        RG_SHARED = 2'd1,
        RG_BANKED = 2'd2,
        RG_CTL3   = 2'd3
    } region_e;

endpackage

// File: rtl/bwin_sync.sv
module bwin_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;   // released lines idle high
            end else begin
                chain <= {chain[STAGES-2:0], d[b]};
            end
        end

        assign q[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/bwin_regfile.sv
module bwin_regfile
    import bwin_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  region_e           region,
    input  bank_e             bank,
    output logic [DATA_W-1:0] rdata,
    output logic              lvl_we
);

    localparam int unsigned HALF  = 2 ** (ADDR_W - 1);
    localparam int unsigned IDX_W = ADDR_W - 1;
    localparam logic [IDX_W-1:0] CTL4_SEL = IDX_W'(CTL4_IDX);

    logic [DATA_W-1:0] low_q [HALF];
    logic [DATA_W-1:0] b0_q  [HALF];
    logic [DATA_W-1:0] b1_q  [HALF];
    logic [DATA_W-1:0] sh_q  [2];

    logic [IDX_W-1:0] idx;
    assign idx = addr[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(HALF); i++) begin
                low_q[i] <= '0;
                b0_q[i]  <= '0;
                b1_q[i]  <= '0;
            end
            sh_q[0] <= '0;
            sh_q[1] <= '0;
        end else if (wr) begin
            unique case (region)
                RG_LOW:    low_q[idx] <= wdata;
                RG_SHARED: sh_q[idx[0]] <= wdata;
                RG_BANKED: begin
                    if (bank == BANK_ONE) b1_q[idx] <= wdata;
                    else                  b0_q[idx] <= wdata;
                end
                default: ;  // control-3 lives in bwin_ctl3
            endcase
        end
    end

    always_comb begin
        unique case (region)
            RG_LOW:    rdata = low_q[idx];
            RG_SHARED: rdata = sh_q[idx[0]];
            RG_BANKED: rdata = (bank == BANK_ONE) ? b1_q[idx] : b0_q[idx];
            default:   rdata = '0;
        endcase
    end

    // Guard bit is taken from bank-0 storage only (R10)
    assign lvl_we = b0_q[CTL4_SEL][LVL_WE_BIT];

    // R10: a bank-1 write can never alter the guard
    p_we_bank0_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && region == RG_BANKED && bank == BANK_ONE) |=> $stable(lvl_we));

endmodule

// File: rtl/bwin_ctl3.sv
module bwin_ctl3
    import bwin_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  region_e           region,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lvl_we,
    input  logic              scl_sync,
    input  logic              sda_sync,
    input  logic              eng_scl_low,
    input  logic              eng_sda_low,
    output bank_e             bank,
    output logic [DATA_W-1:0] rdata,
    output logic              scl_drive_low,
    output logic              sda_drive_low
);

    localparam int unsigned LOW_W = BANK_BIT;

    bank_e            bank_q, bank_d;
    logic [LOW_W-1:0] low_q;
    logic             scl_lvl_q, sda_lvl_q;
    logic             ctl3_wr;

    assign ctl3_wr = wr && (region == RG_CTL3);

    // Bank state machine: BANK_ZERO <-> BANK_ONE
    always_comb begin
        bank_d = bank_q;
        unique case (bank_q)
            BANK_ZERO: if (ctl3_wr && wdata[BANK_BIT])  bank_d = BANK_ONE;   // SEL_HIGH
            BANK_ONE:  if (ctl3_wr && !wdata[BANK_BIT]) bank_d = BANK_ZERO;  // SEL_LOW
            default:   bank_d = BANK_ZERO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= BANK_ZERO;
        else        bank_q <= bank_d;
    end

    // Remaining control-3 fields, with the level-write guard
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q     <= '0;
            scl_lvl_q <= 1'b1;
            sda_lvl_q <= 1'b1;
        end else if (ctl3_wr) begin
            low_q <= wdata[LOW_W-1:0];
            if (lvl_we) begin
                scl_lvl_q <= wdata[SCL_BIT];
                sda_lvl_q <= wdata[SDA_BIT];
            end
        end
    end

    // Outputs
    always_comb begin
        bank          = bank_q;
        scl_drive_low = eng_scl_low | ~scl_lvl_q;
        sda_drive_low = eng_sda_low | ~sda_lvl_q;
        rdata         = '0;
        rdata[SCL_BIT]       = scl_sync;
        rdata[SDA_BIT]       = sda_sync;
        rdata[BANK_BIT]      = (bank_q == BANK_ONE);
        rdata[LOW_W-1:0]     = low_q;
    end

    // R2: the bank follows the written select bit
    p_bank_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl3_wr |=> (bank == ($past(wdata[BANK_BIT]) ? BANK_ONE : BANK_ZERO)));

    // R6: a closed guard keeps both levels
    p_guard_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_we |=> ($stable(scl_lvl_q) && $stable(sda_lvl_q)));

    // R8: engine pull-low always reaches the pins
    p_engine_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_scl_low || eng_sda_low) |->
            ((!eng_scl_low || scl_drive_low) && (!eng_sda_low || sda_drive_low)));

    // R7: an opened guard writing 0 to the clock level pulls the clock low
    p_override_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl3_wr && lvl_we && !wdata[SCL_BIT]) |=> scl_drive_low);

endmodule

// File: rtl/i2c_reg_window.sv
module i2c_reg_window
    import bwin_pkg::*;
#(
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_scl_low,
    input  logic              eng_sda_low,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low
);

    localparam int unsigned IDX_W = ADDR_W - 1;
    localparam logic [ADDR_W-1:0] CTL3_ADDR = ADDR_W'(CTL3_OFF);
    localparam logic [IDX_W-1:0]  SH_A      = IDX_W'(SHARED_A);
    localparam logic [IDX_W-1:0]  SH_B      = IDX_W'(SHARED_B);

    region_e           region;
    bank_e             bank;
    logic              lvl_we;
    logic [1:0]        pins_sync;
    logic [DATA_W-1:0] plain_rd, ctl3_rd;

    // Offset decode
    always_comb begin
        if (reg_addr == CTL3_ADDR)
            region = RG_CTL3;
        else if (!reg_addr[ADDR_W-1])
            region = RG_LOW;
        else if (reg_addr[IDX_W-1:0] == SH_A || reg_addr[IDX_W-1:0] == SH_B)
            region = RG_SHARED;
        else
            region = RG_BANKED;
    end

    bwin_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (pins_sync)
    );

    bwin_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .region (region),
        .bank   (bank),
        .rdata  (plain_rd),
        .lvl_we (lvl_we)
    );

    bwin_ctl3 #(.DATA_W(DATA_W)) u_ctl3 (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr            (reg_wr),
        .region        (region),
        .wdata         (reg_wdata),
        .lvl_we        (lvl_we),
        .scl_sync      (pins_sync[1]),
        .sda_sync      (pins_sync[0]),
        .eng_scl_low   (eng_scl_low),
        .eng_sda_low   (eng_sda_low),
        .bank          (bank),
        .rdata         (ctl3_rd),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low)
    );

    assign reg_rdata = (region == RG_CTL3) ? ctl3_rd : plain_rd;

endmodule

// File: tb/i2c_reg_window_tb.sv
module i2c_reg_window_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;
    localparam logic [1:0] OPW = 2'd0;
    localparam logic [1:0] OPR = 2'd1;

    // {op, addr, data, expected}
    localparam logic [22:0] VEC [NVEC] = '{
        {OPW, 5'h10, 8'hA1, 8'h00},  // bank0 0x10 (R3)
        {OPW, 5'h18, 8'h55, 8'h00},  // shared (R4)
        {OPW, 5'h03, 8'h3C, 8'h00},  // low half (R5)
        {OPW, 5'h0E, 8'h20, 8'h00},  // bank1, levels 0 but guard closed (R2, R6)
        {OPR, 5'h0E, 8'h00, 8'hE0},  // R2 bank bit, R6 levels still high
        {OPR, 5'h10, 8'h00, 8'h00},  // R3 bank1 fresh
        {OPW, 5'h10, 8'hB2, 8'h00},
        {OPW, 5'h1A, 8'h80, 8'h00},  // R10 bank1 0x1A
        {OPR, 5'h18, 8'h00, 8'h55},  // R4
        {OPR, 5'h03, 8'h00, 8'h3C},  // R5
        {OPW, 5'h19, 8'h66, 8'h00},  // R4 written in bank1
        {OPW, 5'h0E, 8'h00, 8'h00},  // bank0, levels 0 attempted (R6)
        {OPR, 5'h0E, 8'h00, 8'hC0},  // R6
        {OPR, 5'h10, 8'h00, 8'hA1},  // R3
        {OPR, 5'h19, 8'h00, 8'h66},  // R4
        {OPR, 5'h1A, 8'h00, 8'h00},  // R10 guard byte untouched
        {OPW, 5'h0E, 8'h20, 8'h00},
        {OPR, 5'h10, 8'h00, 8'hB2},  // R3
        {OPR, 5'h1A, 8'h00, 8'h80},  // R10 bank1 copy
        {OPW, 5'h0E, 8'h00, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       eng_scl_low = 1'b0, eng_sda_low = 1'b0;
    logic       ext_scl_low = 1'b0, ext_sda_low = 1'b0;
    logic       scl_drive_low, sda_drive_low;
    logic       scl_pin, sda_pin;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Wired-AND open-drain bus
    assign scl_pin = ~(scl_drive_low | ext_scl_low);
    assign sda_pin = ~(sda_drive_low | ext_sda_low);

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_reg_window u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_addr      (reg_addr),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .eng_scl_low   (eng_scl_low),
        .eng_sda_low   (eng_sda_low),
        .scl_in        (scl_pin),
        .sda_in        (sda_pin),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [4:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        rd_check("R1 ctl3", 5'h0E, 8'hC0);
        rd_check("R1 guard byte", 5'h1A, 8'h00);
        rd_check("R1 bank0 byte", 5'h10, 8'h00);
        check("R1 drives", {6'd0, scl_drive_low, sda_drive_low}, 8'h00);

        // Table walk (R2..R6, R10)
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][22:21] == OPW) begin
                wr_reg(VEC[i][20:16], VEC[i][15:8]);
            end else begin
                @(negedge clk);
                rd_check($sformatf("R2-5/R6/R10 vec%0d", i), VEC[i][20:16], VEC[i][7:0]);
            end
        end
        check("R6 drives after closed write", {6'd0, scl_drive_low, sda_drive_low}, 8'h00);

        // R8 engine request passes through
        @(negedge clk);
        eng_scl_low = 1'b1;
        #1 check("R8 engine scl", {7'd0, scl_drive_low}, 8'h01);
        check("R8 sda idle", {7'd0, sda_drive_low}, 8'h00);
        @(negedge clk); @(negedge clk);
        rd_check("R8 R9 pin low seen", 5'h0E, 8'h40);
        eng_scl_low = 1'b0;
        eng_sda_low = 1'b1;
        #1 check("R8 engine sda", {6'd0, scl_drive_low, sda_drive_low}, 8'h01);
        eng_sda_low = 1'b0;

        // R7 open guard and pull the clock low
        wr_reg(5'h1A, 8'h80);
        wr_reg(5'h0E, 8'h40);
        check("R7 scl override low", {6'd0, scl_drive_low, sda_drive_low}, 8'h02);
        // one edge after the pin fell: not yet visible (R9)
        @(negedge clk);
        rd_check("R9 latency first edge", 5'h0E, 8'hC0);
        @(negedge clk);
        rd_check("R9 latency second edge", 5'h0E, 8'h40);

        // R7 release clock, pull data low
        wr_reg(5'h0E, 8'h80);
        check("R7 swap", {6'd0, scl_drive_low, sda_drive_low}, 8'h01);

        // R8 release does not force high: external device holds clock
        ext_scl_low = 1'b1;
        @(negedge clk); @(negedge clk);
        rd_check("R8 external hold", 5'h0E, 8'h00);
        check("R8 no drive from release", {7'd0, scl_drive_low}, 8'h00);
        ext_scl_low = 1'b0;

        // R6 close guard; levels frozen
        wr_reg(5'h1A, 8'h00);
        wr_reg(5'h0E, 8'hC3);
        check("R6 data stays low", {6'd0, scl_drive_low, sda_drive_low}, 8'h01);
        @(negedge clk); @(negedge clk);
        rd_check("R6 low bits still written", 5'h0E, 8'h83);

        // R10 open attempt from bank 1 leaves guard closed
        wr_reg(5'h0E, 8'h20);
        wr_reg(5'h1A, 8'h80);
        wr_reg(5'h0E, 8'hE0);
        check("R10 guard still closed", {6'd0, scl_drive_low, sda_drive_low}, 8'h01);

        done = 1'b1;
        finish_run();
    end

endmodule